// File: doc/BRIEF.md
# NAND Micro-Command Queue Sequencer

This block lets software drive an 8-bit asynchronous NAND bus by posting 32-bit micro-command words into a queue. Software does not toggle pins directly. A sequencer takes the words one at a time, in arrival order, and turns each into a bus action. The actions are a command-latch cycle, an address-latch cycle, a single-byte write, a single-byte read, a timed pause, or a wait for a chip's ready/busy line with a timeout. Up to two chips share the bus, and each has its own active-low enable.

Software pushes words through a small register port. It polls the occupancy count until it reads zero, and then knows that all posted work has finished. The byte from the most recent read cycle sits in a buffer register. A status register reports the synchronised ready line of each chip and three sticky flags: wait timeout, queue overflow and interrupt pending. A configuration bit gates the interrupt output.

Top module: `nand_cmdq_seq`

## Requirements
- R1: A write to register 0 enqueues the word. Reading register 0 returns, in bits [27:22], the number of entries not yet retired. The entry currently executing is included in this number. The field reads zero once all work is done, and 32 when the queue is full.
- R2: Operation code 0x5 in bits [17:14] produces a latch cycle with `nand_cle` high. `nand_we_n` is low for exactly PULSE clocks, and `nand_dq_o` carries bits [7:0] with `nand_dq_oe` high.
- R3: Operation code 0x6 produces the same cycle with `nand_ale` high instead of `nand_cle`.
- R4: Operation code 0x4 produces a data write cycle with both latch enables low. The byte in bits [7:0] is driven with the output enable high.
- R5: Operation code 0x8 pulses `nand_re_n` low for PULSE clocks with the bus released. It stores the sampled byte in bits [7:0] of register 3, where bits [31:8] read zero. Each read overwrites the previous byte.
- R6: Bits [11:10] of each word drive `nand_ce_n[1:0]` directly: pattern 0xE in bits [13:10] selects chip 0 and 0xD selects chip 1. After reset both enables are high.
- R7: Operation code 0xC stalls the sequencer for N+1 clocks, where N is bits [7:0], before the entry retires.
- R8: A word with bit 20 set waits on the ready line of the chip whose enable bit is low. It retires once that line reads high. Register 2 bit 26+x shows the synchronised ready state of chip x.
- R9: If the ready line stays low, the wait entry retires after bits [7:0] × 256 clocks. Register 2 bit 0 is then set and stays set until a 1 is written to it.
- R10: A wait word with bit 14 set sets register 2 bit 2 when it retires. `irq` is high while that bit and register 1 bit 21 are both set. Writing 1 to register 2 bit 2 clears it.
- R11: A write to register 0 while 32 entries are pending is discarded. It sets register 2 bit 1, which stays set until a 1 is written to it.
- R12: Entries execute strictly in push order. `nand_we_n` and `nand_re_n` are never low together, and `nand_cle` and `nand_ale` are never high together.
- R13: After reset the count is zero, all flags are clear, strobes and enables are high, and latch enables, output enable and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write index (0 queue, 1 config, 2 status, 3 buffer) |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read index |
| rd_data | output | 32 | Read data, valid one clock after `rd_en` |
| nand_ce_n | output | 2 | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus data output enable |
| nand_dq_i | input | 8 | Bus data in |
| nand_rb | input | 2 | Ready/busy per chip, high when ready |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a single register port. A write to the status register and a queue push can therefore never land in the same clock. They also assume that every executed word carries a chip-enable pattern selecting at most one chip. The bench only ever issues one register access per clock, and only uses the patterns 0xE and 0xD. It holds `nand_dq_i` steady for the whole of a read cycle and changes `nand_rb` only while the relevant wait is pending, so the sampled byte and the ready edge are never ambiguous.

// File: rtl/nand_cmdq_pkg.sv
package nand_cmdq_pkg;
  localparam int unsigned OP_LSB  = 14;
  localparam int unsigned CE_LSB  = 10;
  localparam int unsigned RB_BIT  = 20;
  localparam int unsigned IRQ_BIT = 14;
  localparam int unsigned CNT_LSB = 22;
  localparam int unsigned RDY_LSB = 26;
  localparam int unsigned IEN_BIT = 21;

  localparam logic [3:0] OP_CLE  = 4'h5;
  localparam logic [3:0] OP_ALE  = 4'h6;
  localparam logic [3:0] OP_DWR  = 4'h4;
  localparam logic [3:0] OP_DRD  = 4'h8;
  localparam logic [3:0] OP_IDLE = 4'hC;

  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_CFG  = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_BUF  = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_STRB, S_RECV, S_PAUSE, S_WAITRB, S_DONE
  } seq_state_e;
endpackage

// File: rtl/nand_cmdq_sync.sv
module nand_cmdq_sync (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      q_o    <= 1'b0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/nand_cmdq_fifo.sv
module nand_cmdq_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
    head <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  assert_pop_nonempty_R1: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
endmodule

// File: rtl/nand_cmdq_exec.sv
module nand_cmdq_exec
  import nand_cmdq_pkg::*;
#(
  parameter int unsigned NCHIP     = 2,
  parameter int unsigned PULSE     = 3,
  parameter int unsigned TMO_SHIFT = 8,
  localparam int unsigned CHIP_W   = (NCHIP > 1) ? $clog2(NCHIP) : 1,
  localparam int unsigned CTR_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             q_avail,
  input  logic [31:0]      head,
  output logic             pop,
  input  logic [NCHIP-1:0] rb_ready,
  input  logic [7:0]       dq_i,
  output logic [NCHIP-1:0] ce_n,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [7:0]       dq_o,
  output logic             dq_oe,
  output logic [7:0]       rd_byte,
  output logic             tmo_evt,
  output logic             irq_evt
);
  seq_state_e            st;
  logic [CTR_W-1:0]      ctr;
  logic [7:0]            units;
  logic [TMO_SHIFT-1:0]  tick;
  logic [CHIP_W-1:0]     wchip, sel;
  logic                  irq_req, is_rd;
  logic [3:0]            op;

  assign op = head[OP_LSB +: 4];

  always_comb begin
    sel = '0;
    for (int i = NCHIP - 1; i >= 0; i--) begin
      if (!head[CE_LSB + i]) sel = CHIP_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      ctr     <= '0;
      units   <= '0;
      tick    <= '0;
      wchip   <= '0;
      irq_req <= 1'b0;
      is_rd   <= 1'b0;
      pop     <= 1'b0;
      ce_n    <= '1;
      cle     <= 1'b0;
      ale     <= 1'b0;
      we_n    <= 1'b1;
      re_n    <= 1'b1;
      dq_o    <= '0;
      dq_oe   <= 1'b0;
      rd_byte <= '0;
      tmo_evt <= 1'b0;
      irq_evt <= 1'b0;
    end else begin
      pop     <= 1'b0;
      tmo_evt <= 1'b0;
      irq_evt <= 1'b0;
      case (st)
        S_IDLE: if (q_avail) st <= S_FETCH;
        S_FETCH: begin
          ce_n <= head[CE_LSB +: NCHIP];
          if (head[RB_BIT]) begin
            wchip   <= sel;
            units   <= head[7:0];
            tick    <= '0;
            irq_req <= head[IRQ_BIT];
            st      <= S_WAITRB;
          end else begin
            case (op)
              OP_CLE, OP_ALE, OP_DWR: begin
                cle   <= (op == OP_CLE);
                ale   <= (op == OP_ALE);
                we_n  <= 1'b0;
                dq_o  <= head[7:0];
                dq_oe <= 1'b1;
                ctr   <= CTR_W'(PULSE - 1);
                st    <= S_STRB;
              end
              OP_DRD: begin
                re_n  <= 1'b0;
                is_rd <= 1'b1;
                ctr   <= CTR_W'(PULSE - 1);
                st    <= S_STRB;
              end
              OP_IDLE: begin
                ctr <= head[7:0];
                st  <= S_PAUSE;
              end
              default: begin
                pop <= 1'b1;
                st  <= S_DONE;
              end
            endcase
          end
        end
        S_STRB: begin
          if (ctr == '0) begin
            we_n <= 1'b1;
            re_n <= 1'b1;
            if (is_rd) rd_byte <= dq_i;
            ctr  <= CTR_W'(PULSE - 1);
            st   <= S_RECV;
          end else begin
            ctr <= ctr - 1'b1;
          end
        end
        S_RECV: begin
          if (ctr == '0) begin
            cle   <= 1'b0;
            ale   <= 1'b0;
            dq_oe <= 1'b0;
            is_rd <= 1'b0;
            pop   <= 1'b1;
            st    <= S_DONE;
          end else begin
            ctr <= ctr - 1'b1;
          end
        end
        S_PAUSE: begin
          if (ctr == '0) begin
            pop <= 1'b1;
            st  <= S_DONE;
          end else begin
            ctr <= ctr - 1'b1;
          end
        end
        S_WAITRB: begin
          tick <= tick + 1'b1;
          if (rb_ready[wchip] || units == '0) begin
            tmo_evt <= !rb_ready[wchip];
            irq_evt <= irq_req;
            pop     <= 1'b1;
            st      <= S_DONE;
          end else if (tick == '1) begin
            units <= units - 1'b1;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));
  assert_latch_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(cle && ale));
  assert_drive_on_write_R4: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> dq_oe);
  assert_release_on_read_R5: assert property (@(posedge clk) disable iff (rst)
    !re_n |-> !dq_oe);
  assert_pop_single_R1: assert property (@(posedge clk) disable iff (rst)
    pop |=> !pop);
endmodule

// File: rtl/nand_cmdq_seq.sv
module nand_cmdq_seq
  import nand_cmdq_pkg::*;
#(
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned NCHIP     = 2,
  parameter int unsigned PULSE     = 3,
  parameter int unsigned TMO_SHIFT = 8,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [31:0]      rd_data,
  output logic [NCHIP-1:0] nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_o,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_i,
  input  logic [NCHIP-1:0] nand_rb,
  output logic             irq
);
  logic             push, pop, full;
  logic [31:0]      head;
  logic [CNT_W-1:0] count;
  logic [NCHIP-1:0] rdy;
  logic [7:0]       rd_byte;
  logic             tmo_evt, irq_evt;
  logic [31:0]      cfg_q;
  logic             tmo_q, ovf_q, pend_q;
  logic [31:0]      stat_w, cnt_w;

  assign push = wr_en && (wr_addr == RA_CMD);

  nand_cmdq_fifo #(.DEPTH(DEPTH), .WIDTH(32)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data(wr_data), .pop(pop),
    .head(head), .count(count), .full(full)
  );

  for (genvar g = 0; g < NCHIP; g++) begin : g_rb
    nand_cmdq_sync u_sync (.clk(clk), .rst(rst), .d_i(nand_rb[g]), .q_o(rdy[g]));
  end

  nand_cmdq_exec #(.NCHIP(NCHIP), .PULSE(PULSE), .TMO_SHIFT(TMO_SHIFT)) u_exec (
    .clk(clk), .rst(rst), .q_avail(count != '0), .head(head), .pop(pop),
    .rb_ready(rdy), .dq_i(nand_dq_i), .ce_n(nand_ce_n), .cle(nand_cle),
    .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n), .dq_o(nand_dq_o),
    .dq_oe(nand_dq_oe), .rd_byte(rd_byte), .tmo_evt(tmo_evt), .irq_evt(irq_evt)
  );

  always_comb begin
    stat_w = '0;
    stat_w[0] = tmo_q;
    stat_w[1] = ovf_q;
    stat_w[2] = pend_q;
    stat_w[RDY_LSB +: NCHIP] = rdy;
    cnt_w = '0;
    cnt_w[CNT_LSB +: CNT_W] = count;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      tmo_q   <= 1'b0;
      ovf_q   <= 1'b0;
      pend_q  <= 1'b0;
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_en && wr_addr == RA_CFG) cfg_q <= wr_data;
      if (tmo_evt) tmo_q <= 1'b1;
      else if (wr_en && wr_addr == RA_STAT && wr_data[0]) tmo_q <= 1'b0;
      if (push && full) ovf_q <= 1'b1;
      else if (wr_en && wr_addr == RA_STAT && wr_data[1]) ovf_q <= 1'b0;
      if (irq_evt) pend_q <= 1'b1;
      else if (wr_en && wr_addr == RA_STAT && wr_data[2]) pend_q <= 1'b0;
      irq <= pend_q && cfg_q[IEN_BIT];
      if (rd_en) begin
        case (rd_addr)
          RA_CMD:  rd_data <= cnt_w;
          RA_CFG:  rd_data <= cfg_q;
          RA_STAT: rd_data <= stat_w;
          default: rd_data <= {24'h0, rd_byte};
        endcase
      end
    end
  end

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> ovf_q);
  assert_tmo_flag_R9: assert property (@(posedge clk) disable iff (rst)
    tmo_evt |=> tmo_q);
  assert_irq_pending_R10: assert property (@(posedge clk) disable iff (rst)
    irq_evt |=> pend_q);
endmodule

// File: tb/nand_cmdq_seq_bench.sv
module nand_cmdq_seq_bench;
  localparam int PULSE = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, irq;
  logic [7:0]  nand_dq_o;
  logic [7:0]  nand_dq_i = '0;
  logic [1:0]  nand_rb = 2'b11;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  nand_cmdq_seq #(.PULSE(PULSE)) u_nand_cmdq_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
    .nand_dq_i(nand_dq_i), .nand_rb(nand_rb), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus monitor: kind 0 cmd latch, 1 addr latch, 2 data write, 3 data read
  int          ev_cnt = 0;
  logic [1:0]  last_kind = '0;
  logic [7:0]  last_byte = '0;
  logic [1:0]  last_ce = '0;
  logic [7:0]  cap [64];
  logic        prev_we = 1'b1, prev_re = 1'b1;
  int          low_len = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_we && !nand_we_n) begin
        last_kind = nand_cle ? 2'd0 : (nand_ale ? 2'd1 : 2'd2);
        last_byte = nand_dq_o;
        last_ce   = nand_ce_n;
        cap[ev_cnt % 64] = nand_dq_o;
        ev_cnt++;
        low_len = 0;
      end
      if (prev_re && !nand_re_n) begin
        last_kind = 2'd3;
        last_ce   = nand_ce_n;
        ev_cnt++;
        low_len = 0;
      end
      if (!nand_we_n || !nand_re_n) low_len++;
      if ((!prev_we && nand_we_n) || (!prev_re && nand_re_n))
        check("R2 strobe width", low_len, PULSE);
      prev_we = nand_we_n;
      prev_re = nand_re_n;
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_empty();
    logic [31:0] v;
    for (int k = 0; k < 20000; k++) begin
      reg_read(2'd0, v);
      if (v[27:22] == 6'd0) break;
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] ce, input logic [7:0] b);
    return (32'(op) << 14) | (32'(ce) << 10) | 32'(b);
  endfunction

  function automatic logic [31:0] mkwait(input logic irqr, input logic [3:0] ce, input logic [7:0] u);
    return (32'd1 << 20) | (32'(irqr) << 14) | (32'(ce) << 10) | 32'(u);
  endfunction

  // {op, ce pattern, byte}
  localparam logic [15:0] VEC [0:7] = '{
    16'h5E00, 16'h6E12, 16'h6D34, 16'h4EA5,
    16'h4D5A, 16'h8E3C, 16'h8DC3, 16'h5D30
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    repeat (4) @(negedge clk);

    // R13 reset state
    check("R13 ce_n", 32'(nand_ce_n), 32'h3);
    check("R13 strobes", {nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, irq}, 32'b110000);
    reg_read(2'd0, v); check("R13 R1 count", v, 32'h0);
    reg_read(2'd2, v); check("R13 R8 status", v, 32'h0C00_0000);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      logic [3:0] op; logic [3:0] ce; logic [7:0] b; logic [1:0] kind;
      op = VEC[i][15:12]; ce = VEC[i][11:8]; b = VEC[i][7:0];
      kind = (op == 4'h5) ? 2'd0 : (op == 4'h6) ? 2'd1 : (op == 4'h4) ? 2'd2 : 2'd3;
      base = ev_cnt;
      if (op == 4'h8) begin
        nand_dq_i = b;
        reg_write(2'd0, mk(op, ce, 8'h00));
      end else begin
        reg_write(2'd0, mk(op, ce, b));
      end
      wait_empty();
      check("R2 R3 R4 R5 one bus cycle", 32'(ev_cnt - base), 32'd1);
      check("R2 R3 R4 R5 cycle kind", 32'(last_kind), 32'(kind));
      check("R6 chip enable", 32'(last_ce), 32'(ce[1:0]));
      if (op == 4'h8) begin
        reg_read(2'd3, v); check("R5 read buffer", v, {24'h0, b});
      end else begin
        check("R2 R3 R4 bus byte", 32'(last_byte), 32'(b));
      end
    end

    // R7 timed idle
    reg_write(2'd0, mk(4'hC, 4'hE, 8'd100));
    repeat (60) @(negedge clk);
    reg_read(2'd0, v); check("R7 idle still pending", 32'(v[27:22]), 32'd1);
    repeat (60) @(negedge clk);
    reg_read(2'd0, v); check("R7 idle retired", 32'(v[27:22]), 32'd0);

    // R8 R10 wait ready with interrupt on chip 1
    reg_write(2'd1, 32'h0020_0000);
    nand_rb[1] = 1'b0;
    reg_write(2'd0, mkwait(1'b1, 4'hD, 8'd4));
    repeat (100) @(negedge clk);
    reg_read(2'd0, v); check("R8 wait pending", 32'(v[27:22]), 32'd1);
    reg_read(2'd2, v); check("R8 chip1 busy bit", 32'(v[27:26]), 32'b01);
    check("R10 no irq yet", 32'(irq), 32'd0);
    nand_rb[1] = 1'b1;
    repeat (10) @(negedge clk);
    reg_read(2'd0, v); check("R8 wait retired", 32'(v[27:22]), 32'd0);
    reg_read(2'd2, v); check("R10 R9 flags", v, 32'h0C00_0004);
    check("R10 irq high", 32'(irq), 32'd1);
    reg_write(2'd2, 32'h4);
    repeat (2) @(negedge clk);
    check("R10 irq cleared", 32'(irq), 32'd0);

    // R9 timeout on chip 0, no interrupt request
    nand_rb[0] = 1'b0;
    reg_write(2'd0, mkwait(1'b0, 4'hE, 8'd1));
    repeat (100) @(negedge clk);
    reg_read(2'd0, v); check("R9 waiting", 32'(v[27:22]), 32'd1);
    repeat (300) @(negedge clk);
    reg_read(2'd0, v); check("R9 retired on timeout", 32'(v[27:22]), 32'd0);
    reg_read(2'd2, v); check("R9 timeout flag", v, 32'h0800_0001);
    check("R10 no irq without request", 32'(irq), 32'd0);
    reg_write(2'd2, 32'h1);
    reg_read(2'd2, v); check("R9 flag cleared", 32'(v[2:0]), 32'd0);

    // R11 R12 overflow and ordering
    reg_write(2'd0, mkwait(1'b0, 4'hE, 8'h18));
    base = ev_cnt;
    for (int i = 0; i < 31; i++) reg_write(2'd0, mk(4'h4, 4'hE, 8'(i + 1)));
    reg_read(2'd0, v); check("R1 full count", 32'(v[27:22]), 32'd32);
    reg_write(2'd0, mk(4'h4, 4'hE, 8'hEE));
    reg_read(2'd0, v); check("R11 count unchanged", 32'(v[27:22]), 32'd32);
    reg_read(2'd2, v); check("R11 overflow flag", 32'(v[1:0]), 32'b10);
    nand_rb[0] = 1'b1;
    wait_empty();
    check("R11 dropped word not executed", 32'(ev_cnt - base), 32'd31);
    for (int i = 0; i < 31; i++)
      check("R12 push order", 32'(cap[(base + i) % 64]), 32'(i + 1));
    reg_read(2'd2, v); check("R9 no timeout when ready", 32'(v[0]), 32'd0);
    reg_write(2'd2, 32'h2);
    reg_read(2'd2, v); check("R11 overflow cleared", 32'(v[1]), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule